// File: doc/BRIEF.md
# Edge-Handshake Port Input Latch

This block sits between an eight-bit parallel input (for example the output of a byte-assembling shift register) and a processor's read path. With capture disabled, the read value is simply the live input. With capture enabled, an internal holding register copies the input on every clock. The first active transition on a separate strobe line freezes the holding register, so the processor sees a stable byte however late it reads.

A frozen register ignores every later strobe transition. Only a read of the data-register address clears the freeze, and sampling then restarts from whatever the input carries at that moment. Reads of any other address leave the freeze in place. If the processor does not read in time, the bytes that arrive in the meantime are lost. A software loop that waits for a start-of-frame marker therefore has to perform one throw-away data read before it relies on the next strobe.

Each active strobe transition also raises a pending flag. The same rearming read clears it. The strobe is asynchronous and passes through a synchroniser before edge detection. A control input selects the polarity of the active transition.

Top module: `port_latch_hs`

## Requirements
- R1: After synchronous reset, the pending flag is 0 and the holding register is unfrozen. With the input at 0 and capture enabled, the read value is 0.
- R2: While capture is disabled (`cap_en`=0), `rd_data` equals `port_in` in the same cycle.
- R3: While capture is enabled and not frozen, the holding register loads `port_in` on every rising clock edge, so `rd_data` shows the input from the previous clock.
- R4: An active strobe transition freezes the holding register with the `port_in` value present on the clock where the transition is detected. `rd_data` then stays at that value while the input changes.
- R5: While frozen, further active transitions neither change the held byte nor unfreeze it.
- R6: A read strobe with an address other than the data address (default 4'h1) does not unfreeze the register and does not clear the flag.
- R7: A read strobe at the data address unfreezes the register on that clock. Sampling resumes with the input value present then, whatever it is.
- R8: An active transition sets `pend_flag`. A data-address read clears it on the same clock, unless an active transition is detected on that clock.
- R9: `edge_pol`=1 makes rising strobe transitions active and `edge_pol`=0 makes falling transitions active. A transition of the other direction has no effect.
- R10: When an active transition is detected on the same clock as a rearming data read, that transition is captured. The register holds the input from that clock and the flag stays set.
- R11: A strobe change takes effect at the third rising clock edge after it: two synchroniser stages and one previous-level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | 8 | External parallel input |
| strobe_in | input | 1 | Asynchronous byte-ready strobe |
| cap_en | input | 1 | 1 enables edge-triggered capture |
| edge_pol | input | 1 | Active transition: 1 rising, 0 falling |
| rd_stb | input | 1 | Register read strobe, one clock per read |
| rd_addr | input | 4 | Register address of the read |
| rd_data | output | 8 | Port data read value |
| pend_flag | output | 1 | Pending strobe flag |

## Verification
A freeze bit stuck at 0 lets `rd_data` track the input one clock after the input changes, even though an edge has already been taken. A freeze bit stuck at 1, or a rearm decoded on the wrong address, leaves `rd_data` stale on the clock after the data read. A flag that is not set or not cleared differs at `pend_flag` on the clock right after the edge or the read. A wrong synchroniser depth moves the freeze and the flag rise off the third clock edge after the strobe change, so a count of clock edges exposes it within three cycles.

// File: rtl/port_latch_pkg.sv
package port_latch_pkg;
    localparam int PORT_W = 8;

    typedef logic [PORT_W-1:0] port_byte_t;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic       frozen;
        port_byte_t held;
    } hold_state_t;

    function automatic logic active_edge(edge_pol_e pol, logic cur, logic prev);
        if (pol == POL_RISE)
            return cur & ~prev;
        else
            return ~cur & prev;
    endfunction
endpackage

// File: rtl/pl_sync.sv
module pl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++)
                chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pl_edge.sv
module pl_edge
    import port_latch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic pol,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= level;
    end

    assign hit = active_edge(edge_pol_e'(pol), level, prev_q);
endmodule

// File: rtl/pl_hold.sv
module pl_hold
    import port_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_en,
    input  port_byte_t port_in,
    input  logic       hit,
    input  logic       rearm,
    output port_byte_t held,
    output logic       pend
);
    hold_state_t st_q;
    logic        pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{frozen: 1'b0, held: '0};
        end else if (!cap_en) begin
            st_q <= '{frozen: 1'b0, held: port_in};
        end else if (!st_q.frozen || rearm) begin
            st_q <= '{frozen: hit, held: port_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (hit)
            pend_q <= 1'b1;
        else if (rearm)
            pend_q <= 1'b0;
    end

    assign held = st_q.held;
    assign pend = pend_q;

    assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cap_en && st_q.frozen && !rearm) |=> (st_q.held == $past(st_q.held) && st_q.frozen));

    assert_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !st_q.frozen && !hit) |=> (!st_q.frozen && st_q.held == $past(port_in)));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend_q);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (rearm && !hit) |=> !pend_q);

    assert_coincide_R10: assert property (@(posedge clk) disable iff (rst)
        (cap_en && rearm && hit) |=> (st_q.frozen && st_q.held == $past(port_in)));
endmodule

// File: rtl/port_latch_hs.sv
module port_latch_hs
    import port_latch_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DATA_ADDR   = 4'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] port_in,
    input  logic              strobe_in,
    input  logic              cap_en,
    input  logic              edge_pol,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PORT_W-1:0] rd_data,
    output logic              pend_flag
);
    localparam logic [ADDR_W-1:0] DATA_SEL = ADDR_W'(DATA_ADDR);

    logic       strobe_s;
    logic       hit;
    logic       rearm;
    port_byte_t held;

    assign rearm = rd_stb && (rd_addr == DATA_SEL);

    pl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (strobe_in),
        .q   (strobe_s)
    );

    pl_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (strobe_s),
        .pol   (edge_pol),
        .hit   (hit)
    );

    pl_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .port_in (port_in),
        .hit     (hit),
        .rearm   (rearm),
        .held    (held),
        .pend    (pend_flag)
    );

    assign rd_data = cap_en ? held : port_in;

    assert_other_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr != DATA_SEL && pend_flag) |=> pend_flag);
endmodule

// File: tb/sim_port_latch_hs.sv
`timescale 1ns/1ps
module sim_port_latch_hs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] port_in = 8'h00;
    logic       strobe_in = 1'b0;
    logic       cap_en = 1'b1;
    logic       edge_pol = 1'b1;
    logic       rd_stb = 1'b0;
    logic [3:0] rd_addr = 4'h0;
    logic [7:0] rd_data;
    logic       pend_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    port_latch_hs u0 (
        .clk(clk), .rst(rst), .port_in(port_in), .strobe_in(strobe_in),
        .cap_en(cap_en), .edge_pol(edge_pol), .rd_stb(rd_stb),
        .rd_addr(rd_addr), .rd_data(rd_data), .pend_flag(pend_flag)
    );

    // {value at edge, value after edge, value during ignored edge}
    localparam logic [23:0] VECS [0:5] = '{
        24'h3C_C3_7E, 24'hFF_00_55, 24'h00_FF_AA,
        24'h52_A5_5A, 24'h81_18_E7, 24'h0F_F0_99
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [3:0] a);
        rd_stb  = 1'b1;
        rd_addr = a;
        step(1);
        rd_stb  = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1: reset state
        chk("R1 data", rd_data, 8'h00);
        chk("R1 flag", {7'b0, pend_flag}, 8'h00);

        // Table walk, rising polarity
        for (int i = 0; i < 6; i++) begin
            logic [7:0] va, vb, vc;
            {va, vb, vc} = VECS[i];
            port_in = va;
            step(2);
            strobe_in = 1'b1;
            step(3);
            chk("R4 capture", rd_data, va);
            chk("R8 flag set", {7'b0, pend_flag}, 8'h01);
            port_in = vb;
            step(1);
            chk("R4 held", rd_data, va);
            strobe_in = 1'b0;          // falling: inactive under R9
            step(3);
            chk("R9 wrong edge", rd_data, va);
            port_in = vc;
            strobe_in = 1'b1;          // second active edge: R5 ignored
            step(3);
            chk("R5 ignored edge", rd_data, va);
            strobe_in = 1'b0;
            step(3);
            do_read(4'h2);
            step(1);
            chk("R6 other addr data", rd_data, va);
            chk("R6 other addr flag", {7'b0, pend_flag}, 8'h01);
            do_read(4'h1);
            chk("R7 rearm data", rd_data, vc);
            chk("R8 flag clear", {7'b0, pend_flag}, 8'h00);
        end

        // R3: one-clock lag while following
        port_in = 8'h44;
        step(1);
        port_in = 8'h66;
        #1;
        chk("R3 lag", rd_data, 8'h44);
        step(1);
        chk("R3 follow", rd_data, 8'h66);

        // R11: latency count
        port_in = 8'h21;
        strobe_in = 1'b1;
        step(2);
        chk("R11 not yet", {7'b0, pend_flag}, 8'h00);
        step(1);
        chk("R11 third edge", {7'b0, pend_flag}, 8'h01);
        chk("R11 captured", rd_data, 8'h21);
        strobe_in = 1'b0;
        step(3);

        // R10: edge coinciding with rearming read while frozen
        port_in = 8'h77;
        strobe_in = 1'b1;
        step(2);
        rd_stb = 1'b1; rd_addr = 4'h1; port_in = 8'h5A;
        step(1);
        rd_stb = 1'b0; port_in = 8'hA5;
        step(1);
        chk("R10 captured", rd_data, 8'h5A);
        chk("R10 flag", {7'b0, pend_flag}, 8'h01);
        strobe_in = 1'b0;
        step(3);
        do_read(4'h1);

        // R9: falling polarity
        edge_pol = 1'b0;
        port_in = 8'h10;
        strobe_in = 1'b1;              // rising: inactive now
        step(3);
        chk("R9 rise ignored flag", {7'b0, pend_flag}, 8'h00);
        port_in = 8'h12;
        step(1);
        chk("R9 still following", rd_data, 8'h12);
        port_in = 8'h34;
        strobe_in = 1'b0;              // falling: active
        step(3);
        port_in = 8'h99;
        step(1);
        chk("R9 fall captured", rd_data, 8'h34);
        chk("R9 fall flag", {7'b0, pend_flag}, 8'h01);

        // R2: capture disabled gives live input
        cap_en = 1'b0;
        port_in = 8'hBE;
        #1;
        chk("R2 live", rd_data, 8'hBE);
        port_in = 8'hEF;
        #1;
        chk("R2 live again", rd_data, 8'hEF);
        step(1);
        cap_en = 1'b1;
        step(1);
        chk("R2 reenable follows", rd_data, 8'hEF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule